// File: doc/BRIEF.md
# Halfword Byte-Swapping DMA Bridge

This block sits between a peripheral with a 16-bit data path and a byte-addressed memory port. The peripheral hands over one transfer request at a time. A request names a start address, a byte count, a direction (memory write or memory read) and a flag that bypasses swapping. The bridge combines the request address with a stored base value by bitwise OR, issues one or more memory commands, and moves the byte stream between the two sides over valid/ready handshakes.

In the normal (swapping) mode the bridge rounds the address and the count down to even values. It then exchanges the two bytes of every 16-bit halfword, whichever way the data flows. Memory writes in this mode are cut into commands of bounded size. In bypass mode the bytes pass unchanged: one command covers the full, possibly odd, count at the unmodified combined address. A one-cycle completion pulse closes every request.

Top module: `dmab_bridge`

## Requirements
- R1: After reset the bridge is idle: `req_ready` is 1, `done` is 0, and no command, write byte or read byte is offered on any port. The base register is 0.
- R2: The first memory command of a transfer carries the request address bitwise-ORed with the base register. The base register is loaded from `base_din` in the cycle `base_we` is 1.
- R3: With `req_bypass` = 1, the address bit 0 and the length are kept. Bytes leave in the same order in which they arrived, in both directions.
- R4: With `req_bypass` = 0, bit 0 of the combined address and bit 0 of the length are cleared before any command is issued.
- R5: On a memory write with `req_bypass` = 0, the peripheral bytes p0,p1,p2,p3,... reach `mem_wr_data` as p1,p0,p3,p2,...
- R6: On a memory read with `req_bypass` = 0, the memory bytes m0,m1,m2,m3,... reach `per_rd_data` as m1,m0,m3,m2,...
- R7: A swapped memory write is issued as commands of at most CHUNK (64) bytes each. Each command's address is the previous one plus the previous length, and the lengths sum to the even length. A command is held stable until it is accepted.
- R8: A memory read, and a bypassed memory write, is issued as a single command covering the whole length.
- R9: `done` is high for exactly one cycle once every command has been accepted and every byte has been delivered. `req_ready` is low from request acceptance until after that pulse.
- R10: A request whose length is 0 after rounding raises `done` in the cycle after acceptance and issues no memory command.
- R11: The bridge takes no more source bytes than the effective length. Surplus bytes offered by the source are left unconsumed.
- R12: In swapping mode no byte of a halfword is emitted before both bytes of that halfword have been received. An offered output byte stays stable until it is taken.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| base_we | input | 1 | Load strobe for the base register |
| base_din | input | 32 | New base register value |
| req_valid | input | 1 | Transfer request offered |
| req_ready | output | 1 | Bridge idle, request accepted when valid |
| req_addr | input | 32 | Request start address |
| req_len | input | 16 | Request length in bytes |
| req_write | input | 1 | 1 = memory write, 0 = memory read |
| req_bypass | input | 1 | 1 = no rounding and no swapping |
| per_wr_valid | input | 1 | Peripheral write byte valid |
| per_wr_ready | output | 1 | Bridge takes peripheral write byte |
| per_wr_data | input | 8 | Peripheral write byte |
| per_rd_valid | output | 1 | Read byte offered to peripheral |
| per_rd_ready | input | 1 | Peripheral takes read byte |
| per_rd_data | output | 8 | Read byte to peripheral |
| mem_cmd_valid | output | 1 | Memory command offered |
| mem_cmd_ready | input | 1 | Memory accepts command |
| mem_cmd_write | output | 1 | Command direction, 1 = write |
| mem_cmd_addr | output | 32 | Command start address |
| mem_cmd_len | output | 16 | Command length in bytes |
| mem_wr_valid | output | 1 | Write byte offered to memory |
| mem_wr_ready | input | 1 | Memory takes write byte |
| mem_wr_data | output | 8 | Write byte to memory |
| mem_rd_valid | input | 1 | Memory read byte valid |
| mem_rd_ready | output | 1 | Bridge takes memory read byte |
| mem_rd_data | input | 8 | Memory read byte |
| done | output | 1 | One-cycle completion pulse |

## Verification
The assertions watch properties that must hold on every cycle. These are the evenness of address and length in swapping mode, the chunk bound on swapped writes, the absence of empty commands, the stability of commands and output bytes under backpressure, and the single-cycle width of `done`. The actual byte ordering, the OR with the base register, the chunk addresses and the refusal of surplus source bytes depend on a whole transfer. Only the bench's scenarios can show them, by comparing against a model under stalls, gaps, odd lengths and zero lengths.

// File: rtl/dmab_pkg.sv
package dmab_pkg;

    parameter int ADDR_W = 32;
    parameter int LEN_W  = 16;
    parameter int BYTE_W = 8;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [LEN_W-1:0]  len_t;
    typedef logic [BYTE_W-1:0] byte_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2
    } bstate_e;

    typedef struct packed {
        addr_t addr;
        len_t  len;
        logic  wr;
        logic  bypass;
    } xfer_t;

    // Combined address: OR with base, bit 0 dropped when swapping.
    function automatic addr_t form_addr(addr_t a, addr_t base, logic bypass);
        addr_t m;
        m = '1;
        m[0] = bypass;
        return (a | base) & m;
    endfunction

    // Effective length: rounded down to even when swapping.
    function automatic len_t form_len(len_t l, logic bypass);
        len_t m;
        m = '1;
        m[0] = bypass;
        return l & m;
    endfunction

endpackage

// File: rtl/dmab_swap.sv
module dmab_swap
    import dmab_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  clear,
    input  logic  swap_en,
    input  logic  in_valid,
    output logic  in_ready,
    input  byte_t in_data,
    output logic  out_valid,
    input  logic  out_ready,
    output byte_t out_data
);

    byte_t first_q, second_q;
    logic  draining, slot, oidx;
    logic  in_fire, out_fire;

    assign in_ready  = !draining;
    assign out_valid = draining;
    assign in_fire   = in_valid && in_ready;
    assign out_fire  = out_valid && out_ready;
    assign out_data  = (swap_en && !oidx) ? second_q : first_q;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            draining <= 1'b0;
            slot     <= 1'b0;
            oidx     <= 1'b0;
            first_q  <= '0;
            second_q <= '0;
        end else begin
            if (in_fire) begin
                if (!slot) first_q <= in_data;
                else       second_q <= in_data;
                if (swap_en && !slot) begin
                    slot <= 1'b1;
                end else begin
                    slot     <= 1'b0;
                    draining <= 1'b1;
                end
            end
            if (out_fire) begin
                if (swap_en && !oidx) begin
                    oidx <= 1'b1;
                end else begin
                    oidx     <= 1'b0;
                    draining <= 1'b0;
                end
            end
        end
    end

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready && !clear |=> out_valid && $stable(out_data)); // R12

    AST_PAIR_COMPLETE: assert property (@(posedge clk) disable iff (rst)
        $rose(out_valid) && swap_en |-> $past(in_fire) && $past(slot)); // R12

endmodule

// File: rtl/dmab_chunker.sv
module dmab_chunker
    import dmab_pkg::*;
#(
    parameter int CHUNK = 64
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  start,
    input  xfer_t desc,
    output logic  busy,
    output logic  cmd_valid,
    input  logic  cmd_ready,
    output logic  cmd_write,
    output addr_t cmd_addr,
    output len_t  cmd_len
);

    localparam len_t CHUNK_L = len_t'(CHUNK);

    addr_t cur_addr;
    len_t  remain;
    logic  chunked;
    logic  wr_q;

    assign busy      = (remain != '0);
    assign cmd_valid = busy;
    assign cmd_write = wr_q;
    assign cmd_addr  = cur_addr;
    assign cmd_len   = (chunked && remain > CHUNK_L) ? CHUNK_L : remain;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_addr <= '0;
            remain   <= '0;
            chunked  <= 1'b0;
            wr_q     <= 1'b0;
        end else if (start) begin
            cur_addr <= desc.addr;
            remain   <= desc.len;
            chunked  <= desc.wr && !desc.bypass;
            wr_q     <= desc.wr;
        end else if (cmd_valid && cmd_ready) begin
            cur_addr <= cur_addr + addr_t'(cmd_len);
            remain   <= remain - cmd_len;
        end
    end

    AST_CMD_HOLD: assert property (@(posedge clk) disable iff (rst)
        cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_addr) && $stable(cmd_len)); // R7

    AST_NO_EMPTY_CMD: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> cmd_len != '0); // R10

endmodule

// File: rtl/dmab_bridge.sv
module dmab_bridge
    import dmab_pkg::*;
#(
    parameter int CHUNK = 64
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                base_we,
    input  logic [ADDR_W-1:0]   base_din,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [LEN_W-1:0]    req_len,
    input  logic                req_write,
    input  logic                req_bypass,
    input  logic                per_wr_valid,
    output logic                per_wr_ready,
    input  logic [BYTE_W-1:0]   per_wr_data,
    output logic                per_rd_valid,
    input  logic                per_rd_ready,
    output logic [BYTE_W-1:0]   per_rd_data,
    output logic                mem_cmd_valid,
    input  logic                mem_cmd_ready,
    output logic                mem_cmd_write,
    output logic [ADDR_W-1:0]   mem_cmd_addr,
    output logic [LEN_W-1:0]    mem_cmd_len,
    output logic                mem_wr_valid,
    input  logic                mem_wr_ready,
    output logic [BYTE_W-1:0]   mem_wr_data,
    input  logic                mem_rd_valid,
    output logic                mem_rd_ready,
    input  logic [BYTE_W-1:0]   mem_rd_data,
    output logic                done
);

    bstate_e state;
    xfer_t   desc, nd;
    addr_t   base_q;
    len_t    in_cnt, out_cnt;
    logic    run, accept, src_open, cmd_busy;
    logic    sw_in_valid, sw_in_ready, sw_out_valid, sw_out_ready;
    byte_t   sw_in_data, sw_out_data;
    logic    src_fire, dst_fire;

    assign run       = (state == ST_RUN);
    assign req_ready = (state == ST_IDLE);
    assign accept    = req_valid && req_ready;
    assign done      = (state == ST_FIN);

    always_comb begin
        nd.addr   = form_addr(req_addr, base_q, req_bypass);
        nd.len    = form_len(req_len, req_bypass);
        nd.wr     = req_write;
        nd.bypass = req_bypass;
    end

    assign src_open    = run && (in_cnt != desc.len);
    assign sw_in_valid = src_open && (desc.wr ? per_wr_valid : mem_rd_valid);
    assign sw_in_data  = desc.wr ? per_wr_data : mem_rd_data;
    assign per_wr_ready = src_open && desc.wr && sw_in_ready;
    assign mem_rd_ready = src_open && !desc.wr && sw_in_ready;

    assign mem_wr_valid = run && desc.wr && sw_out_valid;
    assign per_rd_valid = run && !desc.wr && sw_out_valid;
    assign mem_wr_data  = sw_out_data;
    assign per_rd_data  = sw_out_data;
    assign sw_out_ready = run && (desc.wr ? mem_wr_ready : per_rd_ready);

    assign src_fire = sw_in_valid && sw_in_ready;
    assign dst_fire = run && sw_out_valid && sw_out_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            base_q  <= '0;
            desc    <= '0;
            in_cnt  <= '0;
            out_cnt <= '0;
        end else begin
            if (base_we) base_q <= base_din;
            unique case (state)
                ST_IDLE: begin
                    if (accept) begin
                        desc    <= nd;
                        in_cnt  <= '0;
                        out_cnt <= '0;
                        state   <= (nd.len == '0) ? ST_FIN : ST_RUN;
                    end
                end
                ST_RUN: begin
                    if (src_fire) in_cnt  <= in_cnt + len_t'(1);
                    if (dst_fire) out_cnt <= out_cnt + len_t'(1);
                    if (out_cnt == desc.len && !cmd_busy) state <= ST_FIN;
                end
                ST_FIN:  state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    dmab_swap u_swap (
        .clk       (clk),
        .rst       (rst),
        .clear     (accept),
        .swap_en   (!desc.bypass),
        .in_valid  (sw_in_valid),
        .in_ready  (sw_in_ready),
        .in_data   (sw_in_data),
        .out_valid (sw_out_valid),
        .out_ready (sw_out_ready),
        .out_data  (sw_out_data)
    );

    dmab_chunker #(.CHUNK(CHUNK)) u_chunk (
        .clk       (clk),
        .rst       (rst),
        .start     (accept),
        .desc      (nd),
        .busy      (cmd_busy),
        .cmd_valid (mem_cmd_valid),
        .cmd_ready (mem_cmd_ready),
        .cmd_write (mem_cmd_write),
        .cmd_addr  (mem_cmd_addr),
        .cmd_len   (mem_cmd_len)
    );

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R9

    AST_CHUNK_BOUND: assert property (@(posedge clk) disable iff (rst)
        mem_cmd_valid && mem_cmd_write && !desc.bypass |-> mem_cmd_len <= len_t'(CHUNK)); // R7

    AST_EVEN_CMD: assert property (@(posedge clk) disable iff (rst)
        mem_cmd_valid && !desc.bypass |-> !mem_cmd_addr[0] && !mem_cmd_len[0]); // R4

    AST_NO_SURPLUS: assert property (@(posedge clk) disable iff (rst)
        run |-> in_cnt <= desc.len); // R11

endmodule

// File: tb/sim_dmab_bridge.sv
`timescale 1ns/1ps
module sim_dmab_bridge;
    import dmab_pkg::*;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic rst, base_we, req_valid, req_ready, req_write, req_bypass;
    logic [31:0] base_din, req_addr;
    logic [15:0] req_len;
    logic per_wr_valid, per_wr_ready, per_rd_valid, per_rd_ready;
    logic [7:0] per_wr_data, per_rd_data, mem_wr_data, mem_rd_data;
    logic mem_cmd_valid, mem_cmd_ready, mem_cmd_write;
    logic [31:0] mem_cmd_addr;
    logic [15:0] mem_cmd_len;
    logic mem_wr_valid, mem_wr_ready, mem_rd_valid, mem_rd_ready, done;

    dmab_bridge u0 (.*);

    int vecs = 0, bad = 0;
    logic [31:0] base_model = '0;

    task automatic chk(string req, string what, longint act, longint exp);
        vecs++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] mem_byte(logic [31:0] a);
        return a[7:0] ^ {a[11:8], a[3:0]} ^ 8'h5A;
    endfunction

    task automatic set_base(logic [31:0] v);
        @(negedge clk);
        base_we = 1'b1; base_din = v;
        @(negedge clk);
        base_we = 1'b0;
        base_model = v;
    endtask

    task automatic xfer(logic [31:0] a, int len, bit wr, bit byp, bit stall, bit gap);
        logic [31:0] eff_a;
        int eff_l, rem, extra, popped, gapc, seen_cmd;
        logic [31:0] ca;
        logic [31:0] cmd_a[$];
        int          cmd_l[$];
        logic [7:0]  srcq[$];
        logic [7:0]  expq[$];
        logic [7:0]  mrq[$];
        logic [7:0]  srcv[$];
        bit fin;
        logic [31:0] om;
        eff_a = (a | base_model) & (byp ? 32'hFFFF_FFFF : 32'hFFFF_FFFE);
        eff_l = byp ? len : (len & ~1);
        extra = 3;
        popped = 0; gapc = 0; seen_cmd = 0; fin = 0;
        rem = eff_l; ca = eff_a;
        while (rem > 0) begin
            int l = (wr && !byp && rem > 64) ? 64 : rem;
            cmd_a.push_back(ca); cmd_l.push_back(l);
            ca += l; rem -= l;
        end
        if (wr) begin
            for (int i = 0; i < len + extra; i++) srcv.push_back(8'((i * 13 + a + 1) & 8'hFF));
            srcq = srcv;
            for (int i = 0; i < eff_l; i++) expq.push_back(srcv[byp ? i : (i ^ 1)]);
        end else begin
            for (int i = 0; i < eff_l; i++) begin
                om = eff_a + 32'(byp ? i : (i ^ 1));
                expq.push_back(mem_byte(om));
            end
        end
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_len = 16'(len);
        req_write = wr; req_bypass = byp;
        #1 chk("R9", "req_ready when idle", req_ready, 1);
        for (int cyc = 0; cyc < 3000 && !fin; cyc++) begin
            @(negedge clk);
            req_valid = 1'b0;
            per_wr_valid = wr && srcq.size() > 0 && !(stall && cyc % 3 == 1);
            if (wr && gap && popped == 1 && gapc < 6) begin
                per_wr_valid = 1'b0; gapc++;
            end
            per_wr_data = (srcq.size() > 0) ? srcq[0] : 8'h00;
            mem_rd_valid = !wr && mrq.size() > 0 && !(stall && cyc % 4 == 1);
            mem_rd_data  = (mrq.size() > 0) ? mrq[0] : 8'h00;
            mem_cmd_ready = !(stall && cyc % 5 < 2);
            mem_wr_ready  = !(stall && cyc % 3 == 0);
            per_rd_ready  = !(stall && cyc % 4 == 2);
            #1;
            if (wr && gap && popped == 1 && gapc > 0 && gapc <= 6)
                chk("R12", "write byte held until halfword complete", mem_wr_valid, 0);
            if (done) begin
                if (eff_l == 0) begin
                    chk("R10", "done cycle for empty request", cyc, 0);
                    chk("R10", "commands for empty request", seen_cmd, 0);
                end else begin
                    chk("R9", "done not in first cycle", (cyc == 0), 0);
                end
                chk("R9", "bytes outstanding at done", expq.size(), 0);
                chk("R7", "commands outstanding at done", cmd_a.size(), 0);
                if (wr) chk("R11", "surplus source bytes left", srcq.size(), len + extra - eff_l);
                fin = 1;
            end else begin
                chk("R9", "req_ready while busy", req_ready, 0);
            end
            if (mem_cmd_valid && mem_cmd_ready) begin
                seen_cmd++;
                if (cmd_a.size() == 0) begin
                    chk("R10", "unexpected command", 1, 0);
                end else begin
                    chk(seen_cmd == 1 ? "R2,R4" : "R7", "command address", mem_cmd_addr, cmd_a[0]);
                    chk(byp ? "R3,R8" : (wr ? "R7" : "R8"), "command length", mem_cmd_len, cmd_l[0]);
                    chk("R8", "command direction", mem_cmd_write, wr);
                    if (!wr) for (int i = 0; i < cmd_l[0]; i++) mrq.push_back(mem_byte(cmd_a[0] + 32'(i)));
                    void'(cmd_a.pop_front()); void'(cmd_l.pop_front());
                end
            end
            if (per_wr_valid && per_wr_ready) begin void'(srcq.pop_front()); popped++; end
            if (mem_rd_valid && mem_rd_ready) void'(mrq.pop_front());
            if (mem_wr_valid && mem_wr_ready) begin
                if (expq.size() == 0) chk("R11", "extra write byte", 1, 0);
                else begin
                    chk(byp ? "R3" : "R5", "write byte order", mem_wr_data, expq[0]);
                    void'(expq.pop_front());
                end
            end
            if (per_rd_valid && per_rd_ready) begin
                if (expq.size() == 0) chk("R11", "extra read byte", 1, 0);
                else begin
                    chk(byp ? "R3" : "R6", "read byte order", per_rd_data, expq[0]);
                    void'(expq.pop_front());
                end
            end
            if (!wr && per_wr_ready) chk("R11", "write source taken during read", 1, 0);
        end
        if (!fin) chk("R9", "watchdog: transfer never completed", 0, 1);
        @(negedge clk);
        per_wr_valid = 1'b0; mem_rd_valid = 1'b0;
        #1;
        chk("R9", "done after pulse", done, 0);
        chk("R9", "req_ready after pulse", req_ready, 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        $display("FAIL R9 watchdog expired: actual 0x0 expected 0x1");
        bad++;
        $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
        $finish;
    end

    initial begin
        rst = 1'b1; base_we = 1'b0; base_din = '0;
        req_valid = 1'b0; req_addr = '0; req_len = '0; req_write = 1'b0; req_bypass = 1'b0;
        per_wr_valid = 1'b0; per_wr_data = '0; per_rd_ready = 1'b0;
        mem_cmd_ready = 1'b0; mem_wr_ready = 1'b0; mem_rd_valid = 1'b0; mem_rd_data = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R1", "req_ready after reset", req_ready, 1);
        chk("R1", "done after reset", done, 0);
        chk("R1", "cmd valid after reset", mem_cmd_valid, 0);
        chk("R1", "write valid after reset", mem_wr_valid, 0);
        chk("R1", "read valid after reset", per_rd_valid, 0);
        xfer(32'h0000_0207, 4, 1'b0, 1'b1, 1'b0, 1'b0);        // R1 base 0, bypass read
        set_base(32'h0000_1000);
        xfer(32'h0000_0203, 9, 1'b1, 1'b0, 1'b0, 1'b0);        // R2 R4 R5
        xfer(32'h0000_0100, 150, 1'b1, 1'b0, 1'b1, 1'b0);      // R7 chunks 64,64,22
        xfer(32'h0000_0101, 149, 1'b1, 1'b1, 1'b1, 1'b0);      // R3 R8 bypass write
        xfer(32'h0000_0031, 10, 1'b0, 1'b0, 1'b1, 1'b0);       // R6 R8
        xfer(32'h0000_0033, 5, 1'b0, 1'b1, 1'b0, 1'b0);        // R3 bypass read
        xfer(32'h0000_0041, 1, 1'b1, 1'b0, 1'b0, 1'b0);        // R10 rounds to zero
        xfer(32'h0000_0041, 0, 1'b0, 1'b1, 1'b0, 1'b0);        // R10 zero bypass
        xfer(32'h0000_0010, 4, 1'b1, 1'b0, 1'b0, 1'b1);        // R12 gap in halfword
        set_base(32'h8000_0300);
        xfer(32'h0000_0421, 128, 1'b1, 1'b0, 1'b1, 1'b0);      // R2 R7 exact two chunks
        xfer(32'h0000_0421, 7, 1'b0, 1'b0, 1'b0, 1'b0);        // R2 R4 R6
        $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
        $finish;
    end

endmodule